// File: doc/BRIEF.md
# USB Device Controller Register and Interrupt File

This block is the register file that a CPU uses to control a USB device controller. The CPU reaches it through a flat 8-bit address with 8-bit write data and a combinational read-data bus. It holds the settings that the transaction engine consumes: per-endpoint transmit byte counts, IN ready flags, DATA0/DATA1 toggle selections and the device address. It also captures what the engine reports back, namely receive byte counts, OUT ready flags and the last start-of-frame number. Four event sources feed a status register. Each status bit clears when the CPU writes a 1 to it, and the OR of the status bits drives one interrupt line.

The ready flags have split ownership. For an IN endpoint, the CPU sets the flag and the engine clears it once the buffer has gone out. For an OUT endpoint, the engine sets the flag and the CPU clears it after draining the buffer. The block also gives indirect access to the PHY's own registers. The CPU loads a 6-bit PHY register address and an 8-bit data byte, then starts a write or a read. The block sends a one-cycle start pulse to a separate PHY-access engine. The command bit stays set, and reads back as busy, until that engine reports completion.

Top module: `usb_ctl_regs`

## Requirements
- R1: After reset every register reads 0x00, `irq` is low, and all control outputs to the engine and the PHY-access engine are 0.
- R2: Addresses 0x00+n (n = 0..3) hold the CPU-written transmit byte count of IN endpoint n, driven on `inCount[8n+7:8n]`. Addresses 0x04+n return the byte count last received on OUT endpoint n, loaded from `outRcvdCnt` on `outRcvdPulse` with `outRcvdEp`=n. CPU writes to 0x04..0x07 have no effect.
- R3: IN ready at 0x08 (bits 3:0, also on `inReady`): writing 1 to a bit sets it and writing 0 leaves it unchanged. `inSentPulse` clears bit `inSentEp`. If a CPU set and an engine clear hit the same bit in one cycle, the bit ends set.
- R4: OUT ready at 0x09 (bits 3:0, also on `outReady`): `outRcvdPulse` sets bit `outRcvdEp`, and a CPU write of 1 clears that bit. If both hit the same bit in one cycle, the bit ends set.
- R5: Interrupt status at 0x0A: bit 0 is set by `sofPulse`, bit 1 by `setupPulse`, bit 2 by `inSentPulse` and bit 3 by `outRcvdPulse`. Writing 1 clears a bit. An event in the same cycle as its clear leaves the bit set.
- R6: `irq` is high exactly when at least one interrupt status bit is set.
- R7: Toggle at 0x0B: bits 3:0 are read/write and driven on `toggle`. Bit n = 0 selects DATA0 and bit n = 1 selects DATA1 for IN endpoint n.
- R8: Device address at 0x0C: 7 bits, read/write, driven on `devAddr`, and it changes only on a CPU write to 0x0C.
- R9: On `sofPulse` the 11-bit `sofFrame` is captured. Bits 7:0 read at 0x0D and bits 10:8 read at 0x0E bits 2:0. Both addresses are read-only.
- R10: The PHY register address at 0x0F (6 bits) and the PHY data at 0x11 (8 bits) are read/write and are driven on `phyRegAddr` and `phyWrData`.
- R11: PHY command at 0x10: when idle (bits 1:0 = 0), writing bit 0 = 1 sets bit 0 and produces a one-cycle `phyWrStart` from the next edge. Writing bit 1 = 1 with bit 0 = 0 does the same for a read on bit 1 and `phyRdStart`. Writing both starts a write only. Any write while busy is ignored.
- R12: `phyDone` clears the command bits. If a read was pending, the PHY data register loads `phyRdData` on the same edge. `phyDone` while idle has no effect.
- R13: Unmapped addresses (0x12..0xFF) and unused register bits read as 0, and writes to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | CPU register address |
| regWe | input | 1 | CPU write strobe, one write per cycle |
| regWrData | input | 8 | CPU write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| irq | output | 1 | Interrupt, OR of the status bits |
| sofPulse | input | 1 | Start-of-frame received |
| sofFrame | input | 11 | Frame number carried by the start-of-frame |
| setupPulse | input | 1 | Setup data available |
| inSentPulse | input | 1 | An IN buffer has been sent |
| inSentEp | input | 2 | Endpoint of `inSentPulse` |
| outRcvdPulse | input | 1 | An OUT buffer has been filled |
| outRcvdEp | input | 2 | Endpoint of `outRcvdPulse` |
| outRcvdCnt | input | 8 | Bytes received in that buffer |
| inCount | output | 32 | Transmit byte counts, endpoint n at bits 8n+7:8n |
| inReady | output | 4 | IN ready flags |
| outReady | output | 4 | OUT ready flags |
| toggle | output | 4 | DATA1 select per IN endpoint |
| devAddr | output | 7 | Device address |
| phyRegAddr | output | 6 | PHY register address |
| phyWrData | output | 8 | Data for a PHY register write |
| phyWrStart | output | 1 | One-cycle PHY write start |
| phyRdStart | output | 1 | One-cycle PHY read start |
| phyDone | input | 1 | PHY-access engine finished |
| phyRdData | input | 8 | Result of a PHY register read |

## Verification
The hardest cases to reach are the same-cycle collisions between the two owners of one bit: a CPU set against an engine clear on an IN ready flag, an engine set against a CPU clear on an OUT ready flag, and an event against its own write-one-to-clear. In these cases the winner decides whether data is lost. The stimulus drives the engine pulse and the CPU write on the same falling edge, so that one rising edge sees both. The result is then read back through the register port. The PHY command is also driven into its busy state, and a second command is issued there to confirm that neither start pulse fires.

// File: rtl/usb_regs_pkg.sv
package usb_regs_pkg;

  localparam int NUM_EP   = 4;
  localparam int EP_IDX_W = $clog2(NUM_EP);
  localparam int ADDR_W   = 8;
  localparam int NUM_IRQ  = 4;

  // Register offsets. IN/OUT count blocks are aligned to NUM_EP.
  localparam logic [ADDR_W-1:0] A_INCNT   = 8'h00;
  localparam logic [ADDR_W-1:0] A_OUTCNT  = 8'h04;
  localparam logic [ADDR_W-1:0] A_INRDY   = 8'h08;
  localparam logic [ADDR_W-1:0] A_OUTRDY  = 8'h09;
  localparam logic [ADDR_W-1:0] A_IRQ     = 8'h0A;
  localparam logic [ADDR_W-1:0] A_TOGGLE  = 8'h0B;
  localparam logic [ADDR_W-1:0] A_DEVADDR = 8'h0C;
  localparam logic [ADDR_W-1:0] A_FRLO    = 8'h0D;
  localparam logic [ADDR_W-1:0] A_FRHI    = 8'h0E;
  localparam logic [ADDR_W-1:0] A_PHYADDR = 8'h0F;
  localparam logic [ADDR_W-1:0] A_PHYCMD  = 8'h10;
  localparam logic [ADDR_W-1:0] A_PHYDATA = 8'h11;

  // Write strobes from the decoder to the datapath
  typedef struct packed {
    logic [NUM_EP-1:0] wrInCnt;
    logic wrInRdy;
    logic wrOutRdy;
    logic wrIrq;
    logic wrToggle;
    logic wrDevAddr;
    logic wrPhyAddr;
    logic wrPhyCmd;
    logic wrPhyData;
  } regStrb_t;

  typedef enum logic [3:0] {
    RS_NONE, RS_INCNT, RS_OUTCNT, RS_INRDY, RS_OUTRDY, RS_IRQ, RS_TOGGLE,
    RS_DEVADDR, RS_FRLO, RS_FRHI, RS_PHYADDR, RS_PHYCMD, RS_PHYDATA
  } rdSel_t;

endpackage

// File: rtl/usb_regs_ctrl.sv
module usb_regs_ctrl
  import usb_regs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWe,
  output regStrb_t            strb,
  output rdSel_t              rdSel,
  output logic [EP_IDX_W-1:0] epSel
);

  always_comb begin
    strb  = '0;
    rdSel = RS_NONE;
    epSel = regAddr[EP_IDX_W-1:0];
    if (regAddr[ADDR_W-1:EP_IDX_W] == A_INCNT[ADDR_W-1:EP_IDX_W]) begin
      rdSel = RS_INCNT;
      strb.wrInCnt[epSel] = regWe;
    end else if (regAddr[ADDR_W-1:EP_IDX_W] == A_OUTCNT[ADDR_W-1:EP_IDX_W]) begin
      rdSel = RS_OUTCNT;   // read-only
    end else begin
      case (regAddr)
        A_INRDY:   begin rdSel = RS_INRDY;   strb.wrInRdy   = regWe; end
        A_OUTRDY:  begin rdSel = RS_OUTRDY;  strb.wrOutRdy  = regWe; end
        A_IRQ:     begin rdSel = RS_IRQ;     strb.wrIrq     = regWe; end
        A_TOGGLE:  begin rdSel = RS_TOGGLE;  strb.wrToggle  = regWe; end
        A_DEVADDR: begin rdSel = RS_DEVADDR; strb.wrDevAddr = regWe; end
        A_FRLO:    rdSel = RS_FRLO;
        A_FRHI:    rdSel = RS_FRHI;
        A_PHYADDR: begin rdSel = RS_PHYADDR; strb.wrPhyAddr = regWe; end
        A_PHYCMD:  begin rdSel = RS_PHYCMD;  strb.wrPhyCmd  = regWe; end
        A_PHYDATA: begin rdSel = RS_PHYDATA; strb.wrPhyData = regWe; end
        default:   rdSel = RS_NONE;
      endcase
    end
  end

  // R13
  strb_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R13
  no_strb_unmapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == RS_NONE) |-> (strb == '0));

endmodule

// File: rtl/usb_regs_dp.sv
module usb_regs_dp
  import usb_regs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_W   = 11,
  parameter int DEVADDR_W = 7,
  parameter int PHYADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrb_t                 strb,
  input  rdSel_t                   rdSel,
  input  logic [EP_IDX_W-1:0]      epSel,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  output logic                     irq,
  input  logic                     sofPulse,
  input  logic [FRAME_W-1:0]       sofFrame,
  input  logic                     setupPulse,
  input  logic                     inSentPulse,
  input  logic [EP_IDX_W-1:0]      inSentEp,
  input  logic                     outRcvdPulse,
  input  logic [EP_IDX_W-1:0]      outRcvdEp,
  input  logic [DATA_W-1:0]        outRcvdCnt,
  output logic [NUM_EP*DATA_W-1:0] inCount,
  output logic [NUM_EP-1:0]        inReady,
  output logic [NUM_EP-1:0]        outReady,
  output logic [NUM_EP-1:0]        toggle,
  output logic [DEVADDR_W-1:0]     devAddr,
  output logic [PHYADDR_W-1:0]     phyRegAddr,
  output logic [DATA_W-1:0]        phyWrData,
  output logic                     phyWrStart,
  output logic                     phyRdStart,
  input  logic                     phyDone,
  input  logic [DATA_W-1:0]        phyRdData
);

  localparam int FRHI_W = FRAME_W - DATA_W;

  logic [NUM_EP-1:0][DATA_W-1:0] inCnt, outCnt;
  logic [NUM_EP-1:0]  inRdy, inRdyNxt, outRdy, outRdyNxt, togReg;
  logic [NUM_IRQ-1:0] irqStat, irqNxt, irqEvt;
  logic [FRAME_W-1:0] frameNum;
  logic [DEVADDR_W-1:0] devAddrReg;
  logic [PHYADDR_W-1:0] phyAddrReg;
  logic [DATA_W-1:0]  phyData;
  logic [1:0]         phyCmd;     // bit0 write pending, bit1 read pending
  logic               phyBusy, wrGo, rdGo;

  // ---- next-state for split-ownership bits ----
  always_comb begin
    inRdyNxt = inRdy;
    if (inSentPulse) inRdyNxt[inSentEp] = 1'b0;
    if (strb.wrInRdy) inRdyNxt = inRdyNxt | wrData[NUM_EP-1:0];   // CPU set wins

    outRdyNxt = outRdy;
    if (strb.wrOutRdy) outRdyNxt = outRdyNxt & ~wrData[NUM_EP-1:0];
    if (outRcvdPulse) outRdyNxt[outRcvdEp] = 1'b1;               // engine set wins

    irqEvt = {outRcvdPulse, inSentPulse, setupPulse, sofPulse};
    irqNxt = irqStat;
    if (strb.wrIrq) irqNxt = irqNxt & ~wrData[NUM_IRQ-1:0];
    irqNxt = irqNxt | irqEvt;                                     // event wins
  end

  assign phyBusy = |phyCmd;
  assign wrGo    = strb.wrPhyCmd && !phyBusy && wrData[0];
  assign rdGo    = strb.wrPhyCmd && !phyBusy && !wrData[0] && wrData[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCnt      <= '0;
      outCnt     <= '0;
      inRdy      <= '0;
      outRdy     <= '0;
      irqStat    <= '0;
      togReg     <= '0;
      devAddrReg <= '0;
      frameNum   <= '0;
      phyAddrReg <= '0;
      phyData    <= '0;
      phyCmd     <= '0;
      phyWrStart <= 1'b0;
      phyRdStart <= 1'b0;
    end else begin
      for (int e = 0; e < NUM_EP; e++) begin
        if (strb.wrInCnt[e]) inCnt[e] <= wrData;
        if (outRcvdPulse && (outRcvdEp == EP_IDX_W'(e))) outCnt[e] <= outRcvdCnt;
      end
      inRdy   <= inRdyNxt;
      outRdy  <= outRdyNxt;
      irqStat <= irqNxt;
      if (strb.wrToggle)  togReg     <= wrData[NUM_EP-1:0];
      if (strb.wrDevAddr) devAddrReg <= wrData[DEVADDR_W-1:0];
      if (strb.wrPhyAddr) phyAddrReg <= wrData[PHYADDR_W-1:0];
      if (sofPulse)       frameNum   <= sofFrame;

      phyWrStart <= wrGo;
      phyRdStart <= rdGo;
      if (wrGo)                 phyCmd <= 2'b01;
      else if (rdGo)            phyCmd <= 2'b10;
      else if (phyDone)         phyCmd <= 2'b00;

      if (phyDone && phyCmd[1]) phyData <= phyRdData;
      else if (strb.wrPhyData)  phyData <= wrData;
    end
  end

  // ---- read mux ----
  always_comb begin
    case (rdSel)
      RS_INCNT:   rdData = inCnt[epSel];
      RS_OUTCNT:  rdData = outCnt[epSel];
      RS_INRDY:   rdData = DATA_W'(inRdy);
      RS_OUTRDY:  rdData = DATA_W'(outRdy);
      RS_IRQ:     rdData = DATA_W'(irqStat);
      RS_TOGGLE:  rdData = DATA_W'(togReg);
      RS_DEVADDR: rdData = DATA_W'(devAddrReg);
      RS_FRLO:    rdData = frameNum[DATA_W-1:0];
      RS_FRHI:    rdData = DATA_W'(frameNum[FRAME_W-1:DATA_W]);
      RS_PHYADDR: rdData = DATA_W'(phyAddrReg);
      RS_PHYCMD:  rdData = DATA_W'(phyCmd);
      RS_PHYDATA: rdData = phyData;
      default:    rdData = '0;
    endcase
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign inCount[e*DATA_W +: DATA_W] = inCnt[e];
  end

  assign irq        = |irqStat;
  assign inReady    = inRdy;
  assign outReady   = outRdy;
  assign toggle     = togReg;
  assign devAddr    = devAddrReg;
  assign phyRegAddr = phyAddrReg;
  assign phyWrData  = phyData;

  // ---- assertions ----
  // R3
  in_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inSentPulse && !(strb.wrInRdy && wrData[inSentEp])) |=> !inReady[$past(inSentEp)]);

  // R3
  in_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrInRdy && wrData[0]) |=> inReady[0]);

  // R4
  out_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    outRcvdPulse |=> outReady[$past(outRcvdEp)]);

  // R5
  sof_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |=> irq);

  // R8
  devaddr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDevAddr |=> $stable(devAddr));

  // R11
  phy_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phyWrStart || phyRdStart) |=> !(phyWrStart || phyRdStart));

  // R11
  phy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(phyWrStart && phyRdStart));

  // R12
  phy_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phyDone && phyBusy) |=> (phyCmd == 2'b00));

endmodule

// File: rtl/usb_ctl_regs.sv
module usb_ctl_regs
  import usb_regs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_W   = 11,
  parameter int DEVADDR_W = 7,
  parameter int PHYADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWe,
  input  logic [DATA_W-1:0]        regWrData,
  output logic [DATA_W-1:0]        regRdData,
  output logic                     irq,
  input  logic                     sofPulse,
  input  logic [FRAME_W-1:0]       sofFrame,
  input  logic                     setupPulse,
  input  logic                     inSentPulse,
  input  logic [EP_IDX_W-1:0]      inSentEp,
  input  logic                     outRcvdPulse,
  input  logic [EP_IDX_W-1:0]      outRcvdEp,
  input  logic [DATA_W-1:0]        outRcvdCnt,
  output logic [NUM_EP*DATA_W-1:0] inCount,
  output logic [NUM_EP-1:0]        inReady,
  output logic [NUM_EP-1:0]        outReady,
  output logic [NUM_EP-1:0]        toggle,
  output logic [DEVADDR_W-1:0]     devAddr,
  output logic [PHYADDR_W-1:0]     phyRegAddr,
  output logic [DATA_W-1:0]        phyWrData,
  output logic                     phyWrStart,
  output logic                     phyRdStart,
  input  logic                     phyDone,
  input  logic [DATA_W-1:0]        phyRdData
);

  regStrb_t            strb;
  rdSel_t              rdSel;
  logic [EP_IDX_W-1:0] epSel;

  usb_regs_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .strb(strb), .rdSel(rdSel), .epSel(epSel)
  );

  usb_regs_dp #(
    .DATA_W(DATA_W), .FRAME_W(FRAME_W), .DEVADDR_W(DEVADDR_W), .PHYADDR_W(PHYADDR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .epSel(epSel),
    .wrData(regWrData), .rdData(regRdData), .irq(irq),
    .sofPulse(sofPulse), .sofFrame(sofFrame), .setupPulse(setupPulse),
    .inSentPulse(inSentPulse), .inSentEp(inSentEp),
    .outRcvdPulse(outRcvdPulse), .outRcvdEp(outRcvdEp), .outRcvdCnt(outRcvdCnt),
    .inCount(inCount), .inReady(inReady), .outReady(outReady), .toggle(toggle),
    .devAddr(devAddr), .phyRegAddr(phyRegAddr), .phyWrData(phyWrData),
    .phyWrStart(phyWrStart), .phyRdStart(phyRdStart),
    .phyDone(phyDone), .phyRdData(phyRdData)
  );

endmodule

// File: tb/test_usb_ctl_regs.sv
`timescale 1ns/1ps
module test_usb_ctl_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        irq;
  logic        sofPulse = 1'b0;
  logic [10:0] sofFrame = '0;
  logic        setupPulse = 1'b0;
  logic        inSentPulse = 1'b0;
  logic [1:0]  inSentEp = '0;
  logic        outRcvdPulse = 1'b0;
  logic [1:0]  outRcvdEp = '0;
  logic [7:0]  outRcvdCnt = '0;
  logic [31:0] inCount;
  logic [3:0]  inReady, outReady, toggle;
  logic [6:0]  devAddr;
  logic [5:0]  phyRegAddr;
  logic [7:0]  phyWrData;
  logic        phyWrStart, phyRdStart;
  logic        phyDone = 1'b0;
  logic [7:0]  phyRdData = '0;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] v;

  always #4 clk = ~clk;   // 125 MHz

  usb_ctl_regs i_usb_ctl_regs (.*);

  // {address, write data, expected read-back}
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    24'h00_40_40, 24'h03_80_80, 24'h05_12_00, 24'h0B_FA_0A, 24'h0C_FF_7F,
    24'h0F_FF_3F, 24'h11_A5_A5, 24'h0E_FF_00, 24'h20_55_00, 24'h0D_33_00
  };

  function automatic string vecTag(int i);
    case (i)
      0, 1, 2: return "R2 count regs";
      3:       return "R7 toggle";
      4:       return "R8 device address";
      5, 6:    return "R10 phy addr/data";
      7, 9:    return "R9 frame read-only";
      default: return "R13 unmapped";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  initial begin
    #(8 * 100000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 18; a++) begin
      rdReg(8'(a), v);
      check("R1 reset read", v, 0);
    end
    check("R1 reset irq", irq, 0);
    check("R1 reset outputs", {inCount, inReady, outReady, toggle, devAddr, phyWrStart, phyRdStart}, 0);

    // Table-driven write/read-back
    for (int i = 0; i < NV; i++) begin
      wrReg(VEC[i][23:16], VEC[i][15:8]);
      rdReg(VEC[i][23:16], v);
      check(vecTag(i), v, VEC[i][7:0]);
    end
    check("R2 inCount pins", {inCount[31:24], inCount[7:0]}, 16'h8040);
    check("R7 toggle pins", toggle, 4'hA);
    check("R8 devAddr pins", devAddr, 7'h7F);
    check("R10 phy pins", {phyRegAddr, phyWrData}, {6'h3F, 8'hA5});

    // R3 IN ready
    wrReg(8'h08, 8'h05);
    check("R3 set bits", inReady, 4'h5);
    wrReg(8'h08, 8'h02);
    rdReg(8'h08, v);
    check("R3 zero bits no effect", v, 8'h07);
    @(negedge clk); inSentEp = 2'd2; inSentPulse = 1'b1;
    @(negedge clk); inSentPulse = 1'b0;
    check("R3 engine clear", inReady, 4'h3);
    rdReg(8'h0A, v);
    check("R5 in event status", v, 8'h04);
    check("R6 irq high", irq, 1);
    @(negedge clk); inSentEp = 2'd0; inSentPulse = 1'b1;
    regAddr = 8'h08; regWrData = 8'h01; regWe = 1'b1;
    @(negedge clk); inSentPulse = 1'b0; regWe = 1'b0;
    check("R3 CPU set wins", inReady, 4'h3);
    wrReg(8'h0A, 8'h0F);
    rdReg(8'h0A, v);
    check("R5 w1c clear", v, 8'h00);
    check("R6 irq low", irq, 0);

    // R4 OUT ready and counts
    @(negedge clk); outRcvdEp = 2'd2; outRcvdCnt = 8'h33; outRcvdPulse = 1'b1;
    @(negedge clk); outRcvdPulse = 1'b0;
    check("R4 engine set", outReady, 4'h4);
    rdReg(8'h06, v);
    check("R2 out count ep2", v, 8'h33);
    wrReg(8'h09, 8'h04);
    rdReg(8'h09, v);
    check("R4 CPU clear", v, 8'h00);
    @(negedge clk); outRcvdEp = 2'd1; outRcvdCnt = 8'h21; outRcvdPulse = 1'b1;
    regAddr = 8'h09; regWrData = 8'h02; regWe = 1'b1;
    @(negedge clk); outRcvdPulse = 1'b0; regWe = 1'b0;
    check("R4 engine set wins", outReady, 4'h2);
    rdReg(8'h05, v);
    check("R2 out count ep1", v, 8'h21);

    // R5/R9 SOF capture with clear in same cycle (status now 0x08)
    @(negedge clk); sofFrame = 11'h5A3; sofPulse = 1'b1;
    regAddr = 8'h0A; regWrData = 8'h09; regWe = 1'b1;
    @(negedge clk); sofPulse = 1'b0; regWe = 1'b0;
    rdReg(8'h0A, v);
    check("R5 event beats clear", v, 8'h01);
    rdReg(8'h0D, v);
    check("R9 frame low", v, 8'hA3);
    rdReg(8'h0E, v);
    check("R9 frame high", v, 8'h05);
    @(negedge clk); setupPulse = 1'b1;
    @(negedge clk); setupPulse = 1'b0;
    rdReg(8'h0A, v);
    check("R5 setup bit", v, 8'h03);
    wrReg(8'h0A, 8'h03);
    check("R6 irq cleared", irq, 0);

    // R11/R12 PHY access
    wrReg(8'h10, 8'h01);
    check("R11 write start pulse", {phyWrStart, phyRdStart}, 2'b10);
    rdReg(8'h10, v);
    check("R11 write busy", v, 8'h01);
    @(negedge clk);
    check("R11 pulse one cycle", {phyWrStart, phyRdStart}, 2'b00);
    wrReg(8'h10, 8'h02);
    check("R11 busy ignores start", phyRdStart, 0);
    rdReg(8'h10, v);
    check("R11 busy cmd unchanged", v, 8'h01);
    @(negedge clk); phyRdData = 8'h9C; phyDone = 1'b1;
    @(negedge clk); phyDone = 1'b0;
    rdReg(8'h10, v);
    check("R12 done clears", v, 8'h00);
    rdReg(8'h11, v);
    check("R12 write keeps data", v, 8'hA5);
    wrReg(8'h10, 8'h02);
    check("R11 read start pulse", {phyWrStart, phyRdStart}, 2'b01);
    @(negedge clk); phyDone = 1'b1;
    @(negedge clk); phyDone = 1'b0;
    rdReg(8'h11, v);
    check("R12 read captured", v, 8'h9C);
    rdReg(8'h10, v);
    check("R12 read done clears", v, 8'h00);
    @(negedge clk); phyRdData = 8'h11; phyDone = 1'b1;
    @(negedge clk); phyDone = 1'b0;
    rdReg(8'h11, v);
    check("R12 idle done ignored", v, 8'h9C);
    wrReg(8'h10, 8'h03);
    check("R11 both bits write only", {phyWrStart, phyRdStart}, 2'b10);
    rdReg(8'h10, v);
    check("R11 both bits cmd", v, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule